// File: doc/BRIEF.md
# Pixel Clock Divider Selector

This block works out the settings of a programmable pixel clock synthesizer from a requested dot frequency. Every frequency it handles is an integer count of 10 kHz steps. Each request carries five values: the wanted frequency, the synthesizer reference frequency, the reference divider, and the lowest and highest frequencies the synthesizer may produce. From these the block picks a post-divider ratio, the 2-bit code that selects that ratio, and a flag that engages an extra external divide stage. It also picks the feedback count N and reports the frequency the settings really produce.

The choice rests on the ratio Q = target × ref_div / (2 × ref_freq). Q is compared against a fixed ladder of fractional limits. The block avoids fractions by scaling both sides of each comparison to integers. It derives N and the achieved frequency with a single shared sequential divider, used twice in turn. A request is started with a one-cycle `start`. The block answers with a one-cycle `done`, and the results stay on the outputs until the next request finishes.

Top module: `pclk_divsel`

## Requirements
- R1: A target greater than `freq_max` finishes with `range_err`=1, and `post_div`, `post_code`, `ext_div`, `fb_count` and `freq_out` all 0. A target equal to `freq_max` is accepted.
- R2: A target below `freq_min` is still computed normally and completes with `low_warn`=1. Otherwise `low_warn`=0.
- R3: For Q ≤ 255 the ladder is tried from the top. Q > 127.5 gives divider 1, code 0, ext 0. Q > 85 gives divider 2, code 1, ext 0. Q > 63.75 gives divider 3, code 0, ext 1. Q > 42.5 gives divider 4, code 2, ext 0. Q > 31.875 gives divider 6, code 2, ext 1. Q > 21.25 gives divider 8, code 3, ext 0. Anything lower gives divider 12, code 3, ext 1. Each comparison is strict, so a Q equal to a limit falls to the next rung.
- R4: When Q > 255, the result is divider 1, code 0, ext 0, with `fb_count` = 255.
- R5: Away from the clamp, `fb_count` is Q × divider rounded to the nearest integer, with halves rounded up.
- R6: `freq_out` = floor(2 × ref_freq × fb_count / (ref_div × divider)).
- R7: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after `start` is taken through the `done` cycle, and low in the cycle after `done`.
- R8: A `start` pulse that arrives while `busy` is high is dropped. The results belong to the request in progress, and no second `done` follows.
- R9: The result outputs change only on the edge that raises `done`, and hold their values in between.
- R10: After reset, `busy`, `done` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| target | input | FW | Requested pixel frequency (10 kHz units) |
| ref_freq | input | FW | Reference frequency (10 kHz units) |
| ref_div | input | FW | Reference divider |
| freq_min | input | FW | Lowest allowed frequency |
| freq_max | input | FW | Highest allowed frequency |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Target above `freq_max` |
| low_warn | output | 1 | Target below `freq_min` |
| post_div | output | 4 | Chosen post-divider ratio |
| post_code | output | 2 | Code for the chosen ratio |
| ext_div | output | 1 | Extra external divide stage needed |
| fb_count | output | 8 | Feedback count N |
| freq_out | output | FW+1 | Achieved frequency (10 kHz units) |

## Verification
The hardest cases to reach from the ports are the points where Q sits exactly on a ladder limit, and the points where Q × divider lands exactly on a half. These are the cases that expose a non-strict comparison or rounding in the wrong direction. The stimulus picks ref_freq and ref_div so that Q equals the target, or the target divided by 2 or by 8. A chosen integer target then places Q exactly on 127.5, 63.75 or 42.5, or just beside them, and gives exact half-way values such as 128.5. A coarse sweep and a realistic reference setting cover the ordinary spread.

// File: rtl/pclk_sel_pkg.sv
package pclk_sel_pkg;

  localparam int NBITS  = 8;  // feedback count width
  localparam int NBANDS = 8;  // clamp rung plus seven ladder rungs

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BAND,
    ST_DIV_N,
    ST_DIV_F,
    ST_FIN
  } state_e;

  typedef struct packed {
    logic       clamp;
    logic       ext;
    logic [1:0] code;
    logic [3:0] pd;
  } band_t;

  // Each ladder limit on Q, multiplied by 16 so that it is an integer.
  function automatic int unsigned band_limit16(input int idx);
    case (idx)
      0:       return 32'd4080;  // 255
      1:       return 32'd2040;  // 127.5
      2:       return 32'd1360;  // 85
      3:       return 32'd1020;  // 63.75
      4:       return 32'd680;   // 42.5
      5:       return 32'd510;   // 31.875
      6:       return 32'd340;   // 21.25
      default: return 32'd0;
    endcase
  endfunction

  function automatic band_t band_entry(input int idx);
    band_t b;
    b = '0;
    case (idx)
      0: begin b.clamp = 1'b1; b.pd = 4'd1; end
      1: begin b.pd = 4'd1; end
      2: begin b.pd = 4'd2; b.code = 2'd1; end
      3: begin b.pd = 4'd3; b.ext = 1'b1; end
      4: begin b.pd = 4'd4; b.code = 2'd2; end
      5: begin b.pd = 4'd6; b.code = 2'd2; b.ext = 1'b1; end
      6: begin b.pd = 4'd8; b.code = 2'd3; end
      default: begin b.pd = 4'd12; b.code = 2'd3; b.ext = 1'b1; end
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pclk_band_pick.sv
module pclk_band_pick
  import pclk_sel_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*FW-1:0] prod,
  input  logic [FW-1:0]   fref,
  output band_t           sel
);
  localparam int CW = 2*FW + 13;

  logic [NBANDS-2:0] above;
  logic [NBANDS-1:0] hit;

  // Q > L  <=>  8*target*ref_div > 16*L*ref_freq
  generate
    for (genvar g = 0; g < NBANDS-1; g++) begin : g_cmp
      assign above[g] = (CW'(prod) << 3) > (CW'(band_limit16(g)) * CW'(fref));
    end
  endgenerate

  always_comb begin
    hit[0] = above[0];
    for (int i = 1; i < NBANDS-1; i++) hit[i] = above[i] & ~above[i-1];
    hit[NBANDS-1] = ~above[NBANDS-2];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NBANDS; i++) if (hit[i]) sel = band_entry(i);
  end

  // The limits fall monotonically, so exactly one rung matches.
  assert_single_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == 1);

endmodule

// File: rtl/pclk_seq_div.sv
module pclk_seq_div #(
  parameter int W = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         fin,
  output logic [W-1:0] quo
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    rem_q, quo_q, den_q;
  logic [CNTW-1:0] cnt_q;
  logic            act_q, fin_q;
  logic [W:0]      rem_sh;
  logic            take;

  assign rem_sh = {rem_q, quo_q[W-1]};
  assign take   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CNTW'(W);
        act_q <= 1'b1;
      end else if (act_q) begin
        rem_q <= take ? W'(rem_sh - {1'b0, den_q}) : rem_sh[W-1:0];
        quo_q <= {quo_q[W-2:0], take};
        if (cnt_q == CNTW'(1)) begin
          act_q <= 1'b0;
          fin_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNTW'(1);
        end
      end
    end
  end

  assign fin = fin_q;
  assign quo = quo_q;

  assert_remainder_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && den_q != '0) |-> (rem_q < den_q));

endmodule

// File: rtl/pclk_divsel.sv
module pclk_divsel
  import pclk_sel_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FW-1:0]    target,
  input  logic [FW-1:0]    ref_freq,
  input  logic [FW-1:0]    ref_div,
  input  logic [FW-1:0]    freq_min,
  input  logic [FW-1:0]    freq_max,
  output logic             busy,
  output logic             done,
  output logic             range_err,
  output logic             low_warn,
  output logic [3:0]       post_div,
  output logic [1:0]       post_code,
  output logic             ext_div,
  output logic [NBITS-1:0] fb_count,
  output logic [FW:0]      freq_out
);
  localparam int PW = 2*FW;
  localparam int DW = 2*FW + 5;

  state_e           state_q;
  logic [FW-1:0]    tgt_q, fref_q, rdiv_q;
  logic             warn_w_q, kick_q;
  band_t            w_sel_q, band_sel;
  logic [NBITS-1:0] w_n_q, n_sat;
  logic [PW-1:0]    prod;
  logic [DW-1:0]    div_num, div_den, div_quo;
  logic [FW:0]      f_sat;
  logic             div_fin;

  assign prod = PW'(tgt_q) * PW'(rdiv_q);

  pclk_band_pick #(.FW(FW)) u_band (
    .clk  (clk),
    .rst_n(rst_n),
    .prod (prod),
    .fref (fref_q),
    .sel  (band_sel)
  );

  // First pass: N = (T*R*pd + F) / (2F).  Second pass: (2F*N) / (R*pd).
  always_comb begin
    if (state_q == ST_DIV_F) begin
      div_num = (DW'(fref_q) << 1) * DW'(w_n_q);
      div_den = DW'(rdiv_q) * DW'(w_sel_q.pd);
    end else begin
      div_num = DW'(prod) * DW'(w_sel_q.pd) + DW'(fref_q);
      div_den = DW'(fref_q) << 1;
    end
  end

  pclk_seq_div #(.W(DW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (kick_q),
    .num  (div_num),
    .den  (div_den),
    .fin  (div_fin),
    .quo  (div_quo)
  );

  assign n_sat = (|div_quo[DW-1:NBITS]) ? '1 : div_quo[NBITS-1:0];
  assign f_sat = (|div_quo[DW-1:FW+1])  ? '1 : div_quo[FW:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_q     <= '0;
      fref_q    <= '0;
      rdiv_q    <= '0;
      warn_w_q  <= 1'b0;
      kick_q    <= 1'b0;
      w_sel_q   <= '0;
      w_n_q     <= '0;
      range_err <= 1'b0;
      low_warn  <= 1'b0;
      post_div  <= '0;
      post_code <= '0;
      ext_div   <= 1'b0;
      fb_count  <= '0;
      freq_out  <= '0;
    end else begin
      kick_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          tgt_q    <= target;
          fref_q   <= ref_freq;
          rdiv_q   <= ref_div;
          warn_w_q <= target < freq_min;
          if (target > freq_max) begin
            range_err <= 1'b1;
            low_warn  <= target < freq_min;
            post_div  <= '0;
            post_code <= '0;
            ext_div   <= 1'b0;
            fb_count  <= '0;
            freq_out  <= '0;
            state_q   <= ST_FIN;
          end else begin
            state_q <= ST_BAND;
          end
        end
        ST_BAND: begin
          w_sel_q <= band_sel;
          w_n_q   <= band_sel.clamp ? '1 : '0;
          kick_q  <= 1'b1;
          state_q <= band_sel.clamp ? ST_DIV_F : ST_DIV_N;
        end
        ST_DIV_N: if (div_fin) begin
          w_n_q   <= n_sat;
          kick_q  <= 1'b1;
          state_q <= ST_DIV_F;
        end
        ST_DIV_F: if (div_fin) begin
          range_err <= 1'b0;
          low_warn  <= warn_w_q;
          post_div  <= w_sel_q.pd;
          post_code <= w_sel_q.code;
          ext_div   <= w_sel_q.ext;
          fb_count  <= w_n_q;
          freq_out  <= f_sat;
          state_q   <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done = (state_q == ST_FIN);
  assign busy = (state_q != ST_IDLE);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ends_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tgt_q) && $stable(fref_q) && $stable(rdiv_q)));
  assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(fb_count) && $stable(freq_out) && $stable(post_div)));
  assert_error_zeroes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && range_err) |-> (fb_count == '0 && freq_out == '0 && post_div == '0));
  assert_ext_matches_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !range_err) |->
      (ext_div == (post_div == 4'd3 || post_div == 4'd6 || post_div == 4'd12)));
  assert_clamp_skips_round_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIV_N) |-> !w_sel_q.clamp);

endmodule

// File: tb/test_pclk_divsel.sv
`timescale 1ns/1ps
module test_pclk_divsel;
  localparam int FW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] target = '0, ref_freq = '0, ref_div = '0, freq_min = '0, freq_max = '0;
  logic          busy, done, range_err, low_warn, ext_div;
  logic [3:0]    post_div;
  logic [1:0]    post_code;
  logic [7:0]    fb_count;
  logic [FW:0]   freq_out;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pclk_divsel #(.FW(FW)) i_pclk_divsel (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .ref_freq(ref_freq), .ref_div(ref_div), .freq_min(freq_min), .freq_max(freq_max),
    .busy(busy), .done(done), .range_err(range_err), .low_warn(low_warn),
    .post_div(post_div), .post_code(post_code), .ext_div(ext_div),
    .fb_count(fb_count), .freq_out(freq_out)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent model written with rational limits p/q: Q > p/q <=> T*R*q > 2F*p.
  task automatic model(input longint t, r, f, mn, mx,
                       output longint e_err, e_warn, e_pd, e_code, e_ext, e_n, e_fo);
    longint tr, f2, num;
    bit     clamp;
    tr = t * r; f2 = 2 * f; clamp = 0;
    e_err = (t > mx); e_warn = (t < mn); e_code = 0; e_ext = 0;
    if (tr > f2 * 255)            begin e_pd = 1; clamp = 1; end
    else if (tr * 2 > f2 * 255)   begin e_pd = 1; end
    else if (tr > f2 * 85)        begin e_pd = 2; e_code = 1; end
    else if (tr * 4 > f2 * 255)   begin e_pd = 3; e_ext = 1; end
    else if (tr * 2 > f2 * 85)    begin e_pd = 4; e_code = 2; end
    else if (tr * 8 > f2 * 255)   begin e_pd = 6; e_code = 2; e_ext = 1; end
    else if (tr * 4 > f2 * 85)    begin e_pd = 8; e_code = 3; end
    else                          begin e_pd = 12; e_code = 3; e_ext = 1; end
    if (clamp) e_n = 255;
    else begin
      num = tr * e_pd;
      e_n = num / f2;
      if (2 * (num % f2) >= f2) e_n++;
    end
    e_fo = (f2 * e_n) / (r * e_pd);
    if (e_err != 0) begin e_pd = 0; e_code = 0; e_ext = 0; e_n = 0; e_fo = 0; end
  endtask

  task automatic drive(input longint t, r, f, mn, mx);
    target = t[FW-1:0]; ref_freq = r[FW-1:0] == 0 ? '0 : f[FW-1:0];
    ref_freq = f[FW-1:0]; ref_div = r[FW-1:0];
    freq_min = mn[FW-1:0]; freq_max = mx[FW-1:0];
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400 && !done; k++) @(negedge clk);
    chk("R7 done seen", done, 1);
  endtask

  task automatic compare(input longint t, r, f, mn, mx, input string what);
    longint e_err, e_warn, e_pd, e_code, e_ext, e_n, e_fo;
    model(t, r, f, mn, mx, e_err, e_warn, e_pd, e_code, e_ext, e_n, e_fo);
    chk({"R1 range_err ", what}, range_err, e_err);
    chk({"R2 low_warn ", what}, low_warn, e_warn);
    chk({"R3 post_div ", what}, post_div, e_pd);
    chk({"R3 post_code ", what}, post_code, e_code);
    chk({"R3 ext_div ", what}, ext_div, e_ext);
    chk({(e_n == 255 && e_pd == 1) ? "R4" : "R5", " fb_count ", what}, fb_count, e_n);
    chk({"R6 freq_out ", what}, freq_out, e_fo);
  endtask

  task automatic run(input longint t, r, f, mn, mx, input string what);
    @(negedge clk);
    drive(t, r, f, mn, mx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({"R7 busy after start ", what}, busy, 1);
    wait_done();
    compare(t, r, f, mn, mx, what);
    @(negedge clk);
    chk({"R7 done one cycle ", what}, done, 0);
    chk({"R7 busy cleared ", what}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 fb_count", fb_count, 0);
    chk("R10 freq_out", freq_out, 0);
    chk("R10 post_div", post_div, 0);
    chk("R10 flags", {range_err, low_warn, ext_div}, 0);
  endtask

  // ref_freq=100, ref_div=200 makes Q equal to the target.
  task automatic t_ladder();
    longint pts[15] = '{255, 200, 128, 127, 86, 85, 64, 63, 43, 42, 32, 31, 22, 21, 5};
    foreach (pts[i]) run(pts[i], 200, 100, 0, 1000, "ladder");
  endtask

  // Q exactly on a limit: Q=T/2 (R=100) and Q=T/8 (R=25).
  task automatic t_exact_limits();
    run(255, 100, 100, 0, 1000, "Q=127.5");
    run(256, 100, 100, 0, 1000, "Q=128");
    run(170, 100, 100, 0, 1000, "Q=85");
    run(510, 25, 100, 0, 1000, "Q=63.75");
    run(340, 25, 100, 0, 1000, "Q=42.5");
    run(255, 25, 100, 0, 1000, "Q=31.875");
    run(170, 25, 100, 0, 1000, "Q=21.25");
  endtask

  task automatic t_round_half();
    run(257, 100, 100, 0, 1000, "R5 half up 128.5");
    run(171, 100, 100, 0, 1000, "R5 Q=85.5");
  endtask

  task automatic t_clamp();
    run(300, 200, 100, 0, 1000, "R4 clamp");
    run(900, 200, 100, 0, 1000, "R4 clamp far");
  endtask

  task automatic t_range();
    run(1001, 200, 100, 0, 1000, "R1 above max");
    run(1000, 25, 100, 0, 1000, "R1 equal max");
    run(40, 200, 100, 50, 1000, "R2 below min");
    run(50, 200, 100, 50, 1000, "R2 equal min");
  endtask

  task automatic t_realistic();
    longint pts[6] = '{2518, 3150, 6500, 13500, 800, 1200};
    foreach (pts[i]) run(pts[i], 33, 1432, 1000, 23000, "realistic");
    run(24000, 33, 1432, 1000, 23000, "R1 realistic above");
  endtask

  task automatic t_busy_ignore();
    longint hold_n, hold_f;
    int extra;
    @(negedge clk);
    drive(2518, 33, 1432, 0, 23000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    drive(300, 200, 100, 0, 1000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    compare(2518, 33, 1432, 0, 23000, "R8 second start dropped");
    hold_n = fb_count; hold_f = freq_out;
    extra = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R8 no second done", extra, 0);
    chk("R9 fb_count held", fb_count, hold_n);
    chk("R9 freq_out held", freq_out, hold_f);
  endtask

  task automatic t_sweep();
    for (int t = 1; t < 600; t += 13) run(t, 200, 100, 0, 1000, "sweep");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nfail++;
        nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ladder();
    t_exact_limits();
    t_round_half();
    t_clamp();
    t_range();
    t_realistic();
    t_busy_ignore();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule